// File: doc/BRIEF.md
# Variable-Step Program Counter

This block holds the fetch address of a processor core that executes from a 64 KB code space. When an instruction finishes, the core raises a step strobe and gives that instruction's byte length. The counter then moves forward by that many bytes. When control flow leaves the sequential path, the core raises a load strobe and supplies the new address. This covers a branch, a jump, a call, a return or an interrupt entry.

The address is registered. A strobe sampled at a rising clock edge is visible on the output after that same edge. The reset is asynchronous and active low, and it places the counter at address zero so that the first fetch comes from the bottom of code space.

Decoding instructions, saving return addresses and reading code memory all belong to neighbouring blocks.

Top module: `vpc_counter`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 16'h0000, and it stays 16'h0000 after release until the first strobe.
- R2: When `step_i` is 1, `load_i` is 0 and `len_i` is 1, 2 or 3, `pc_o` after the clock edge equals the previous `pc_o` plus `len_i`.
- R3: When `step_i` is 1, `load_i` is 0 and `len_i` is 0, `pc_o` is unchanged by the edge.
- R4: When `load_i` is 1 and `step_i` is 0, `pc_o` after the edge equals `dest_i`, for any 16-bit value including 16'h0000 and 16'hFFFF.
- R5: When `load_i` and `step_i` are both 1, `pc_o` after the edge equals `dest_i`, and `len_i` has no effect.
- R6: When neither strobe is 1, `pc_o` is unchanged, whatever `len_i` and `dest_i` carry.
- R7: A sequential advance past 16'hFFFF wraps modulo 65536 (for example 16'hFFFE + 3 gives 16'h0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction-complete strobe |
| len_i | input | 2 | Byte length of the completed instruction (0 = no move, 1..3 bytes) |
| load_i | input | 1 | Non-sequential transfer strobe, wins over step_i |
| dest_i | input | 16 | Address loaded when load_i is 1 |
| pc_o | output | 16 | Current fetch address |

## Verification
On every clock the assertions relate each edge's strobes to the address that follows: a sequential advance by the given length, a hold for length zero or no strobe, the destination on a load, and a move downward whenever the wrap flag is raised. Other behaviour needs the bench's stimulus. That includes the exact wrapped values at the top of code space and loads of the extreme addresses. It also includes the simultaneous load-and-step case with each length, and long random mixes of strobes compared against an independent address model.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
package vpc_pkg;
  // Source chosen for the next address
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_JUMP = 2'd2
  } vpc_src_e;

  // Select with load priority; a zero length is treated as no move
  function automatic vpc_src_e vpc_pick(input logic load, input logic step,
                                         input logic len_nonzero);
    if (load)                     return SRC_JUMP;
    else if (step && len_nonzero) return SRC_SEQ;
    else                          return SRC_HOLD;
  endfunction
endpackage

// File: rtl/vpc_seq_adder.sv
`timescale 1ns/1ps
module vpc_seq_adder #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic              wrap_o
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] sum_full;

  // Modular add: the carry out of the top bit marks a wrap
  always_comb begin
    sum_full = {1'b0, base_i} + SUM_W'(len_i);
    seq_o    = sum_full[ADDR_W-1:0];
    wrap_o   = sum_full[ADDR_W];
  end
endmodule

// File: rtl/vpc_next_sel.sv
`timescale 1ns/1ps
module vpc_next_sel
  import vpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              step_i,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] dest_i,
  output vpc_src_e          src_o,
  output logic [ADDR_W-1:0] nxt_o
);
  always_comb begin
    src_o = vpc_pick(load_i, step_i, |len_i);
    unique case (src_o)
      SRC_JUMP: nxt_o = dest_i;
      SRC_SEQ:  nxt_o = seq_i;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/vpc_counter.sv
`timescale 1ns/1ps
module vpc_counter
  import vpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [1:0]        len_i,
  input  logic              load_i,
  input  logic [15:0]       dest_i,
  output logic [15:0]       pc_o
);
  localparam logic [ADDR_W-1:0] BOOT_ADDR = '0;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              seq_wrap;
  vpc_src_e          next_src;

  vpc_seq_adder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) adder_i (
    .base_i (pc_q),
    .len_i  (len_i),
    .seq_o  (seq_addr),
    .wrap_o (seq_wrap)
  );

  vpc_next_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) sel_i (
    .step_i (step_i),
    .load_i (load_i),
    .len_i  (len_i),
    .cur_i  (pc_q),
    .seq_i  (seq_addr),
    .dest_i (dest_i),
    .src_o  (next_src),
    .nxt_o  (next_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= BOOT_ADDR;
    else        pc_q <= next_addr;
  end

  assign pc_o = pc_q;

  // R1
  boot_addr_chk: assert property (@(posedge clk) !rst_n |=> pc_o == 16'h0000)
    else $error("boot address not zero");

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && len_i != 2'd0) |=> pc_o == 16'($past(pc_o) + 16'($past(len_i))))
    else $error("sequential advance wrong");

  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && len_i == 2'd0) |=> $stable(pc_o))
    else $error("zero length moved counter");

  // R4 R5
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pc_o == $past(dest_i))
    else $error("load target not taken");

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(pc_o))
    else $error("counter moved while idle");

  // R7
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_src == SRC_SEQ && seq_wrap) |=> pc_o < $past(pc_o))
    else $error("wrap did not return low");
endmodule

// File: tb/vpc_counter_tb.sv
`timescale 1ns/1ps
module vpc_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [1:0]  len_i = 2'd0;
  logic        load_i = 1'b0;
  logic [15:0] dest_i = 16'h0000;
  logic [15:0] pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model_pc = 16'h0000;

  always #5 clk = ~clk;

  vpc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .len_i(len_i),
    .load_i(load_i), .dest_i(dest_i), .pc_o(pc_o)
  );

  function automatic logic [15:0] predict(input logic [15:0] cur, input logic st,
                                          input logic [1:0] ln, input logic ld,
                                          input logic [15:0] tgt);
    logic [16:0] wide;
    if (ld) return tgt;
    if (!st) return cur;
    wide = {1'b0, cur} + {15'd0, ln};
    return wide[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (pc_o !== exp) begin
      failures++;
      $display("FAIL %s: pc_o=%h expected=%h", req, pc_o, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, compare at the next negedge
  task automatic cycle(input string req, input logic st, input logic [1:0] ln,
                       input logic ld, input logic [15:0] tgt);
    step_i = st; len_i = ln; load_i = ld; dest_i = tgt;
    model_pc = predict(model_pc, st, ln, ld, tgt);
    @(posedge clk);
    @(negedge clk);
    check(req, model_pc);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: pc_o=%h expected=finish", pc_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    // R1: reset value, held through strobes while in reset
    @(negedge clk);
    step_i = 1'b1; len_i = 2'd3; load_i = 1'b1; dest_i = 16'hABCD;
    @(negedge clk);
    check("R1", 16'h0000);
    step_i = 1'b0; load_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);

    cycle("R2", 1'b1, 2'd1, 1'b0, 16'h1111);   // 0001
    cycle("R2", 1'b1, 2'd2, 1'b0, 16'h2222);   // 0003
    cycle("R2", 1'b1, 2'd3, 1'b0, 16'h3333);   // 0006
    cycle("R3", 1'b1, 2'd0, 1'b0, 16'h4444);   // hold
    cycle("R6", 1'b0, 2'd3, 1'b0, 16'h5555);   // hold
    cycle("R4", 1'b0, 2'd2, 1'b1, 16'h8000);
    cycle("R5", 1'b1, 2'd3, 1'b1, 16'h1234);
    cycle("R5", 1'b1, 2'd1, 1'b1, 16'h00FF);
    cycle("R4", 1'b0, 2'd0, 1'b1, 16'hFFFE);
    cycle("R7", 1'b1, 2'd3, 1'b0, 16'h0000);   // FFFE+3 -> 0001
    if (model_pc !== 16'h0001) begin failures++; $display("FAIL R7: model=%h expected=0001", model_pc); end
    cycle("R4", 1'b0, 2'd1, 1'b1, 16'hFFFF);
    cycle("R7", 1'b1, 2'd1, 1'b0, 16'hAAAA);   // FFFF+1 -> 0000
    cycle("R4", 1'b1, 2'd0, 1'b1, 16'hFFFD);
    cycle("R7", 1'b1, 2'd2, 1'b0, 16'h0000);   // FFFF
    cycle("R7", 1'b1, 2'd2, 1'b0, 16'h0000);   // 0001
    cycle("R4", 1'b0, 2'd0, 1'b1, 16'h0000);

    for (int i = 0; i < 3000; i++) begin
      logic st, ld;
      logic [1:0] ln;
      logic [15:0] tg;
      st = ($urandom % 4) != 0;
      ld = ($urandom % 8) == 0;
      ln = 2'($urandom);
      tg = (($urandom % 4) == 0) ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom);
      cycle(ld ? (st ? "R5" : "R4") : (st ? ((ln == 0) ? "R3" : "R2") : "R6"),
            st, ln, ld, tg);
    end

    // R1: reset mid-run returns to zero
    rst_n = 1'b0;
    model_pc = 16'h0000;
    #1;
    check("R1", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    step_i = 1'b0; load_i = 1'b0;
    @(negedge clk);
    check("R1", 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule